// File: doc/BRIEF.md
# PCIe Request Header Sanity Checker

This block screens the header of every inbound PCIe transaction layer packet against a set of optional well-formedness rules. The rules cover four things. A 4-DW memory header must carry an address that needs more than 32 bits. Byte enables must agree with the packet length. IO and configuration requests must use default traffic class, default attributes and a single-dword length. A completion that reports configuration-retry status must answer a configuration request that this port actually sent. One enable input turns all four rules on or off together.

The header arrives as three dwords, qualified by a one-cycle valid strobe. The block also watches the port's outbound non-posted requests. For each tag it remembers whether the request was a configuration access, so that returning completions can be judged. One cycle after each header, the block presents a malformed flag and a one-hot-per-rule reason vector. Payload, ECRC, flow control, error message generation and the unconditional protocol checks belong to other blocks.

Top module: `tlp_hdr_check`

## Requirements
- R1: While `chkEnable` is 0, no header produces a set reason bit or a raised `malformed`, whatever its contents.
- R2: A memory read or write with a 4-DW header (DW0[31:29] = 001 or 011, DW0[28:24] = 00000) whose address bits [39:32] (DW2[7:0]) are all zero sets reason bit 0. A 3-DW memory header never sets bit 0.
- R3: For a memory request (DW0[31:29] in 000..011, type 00000) or an IO/config request (R5 encodings) whose length field DW0[9:0] is not 1, reason bit 1 is set when the first byte enables DW1[3:0] are 0 or the last byte enables DW1[7:4] are 0. A length field of 0 counts as 1024 dwords.
- R4: For the same request classes with length field exactly 1, reason bit 1 is set when DW1[7:4] is nonzero, and it is clear when DW1[7:4] is zero, whatever DW1[3:0] holds.
- R5: An IO read/write (type 00010) or a configuration type 0/1 read/write (type 00100/00101), with DW0[31:29] equal to 000 or 010, sets reason bit 2 when TC DW0[22:20] is nonzero, when attributes DW0[13:12] are nonzero, or when the length field is not 1.
- R6: An outbound request pulse (`outReqValid`) records `outReqIsCfg` under `outReqTag`. A completion (DW0[31:29] = 000 or 010, type 01010) looks up its tag DW2[15:8] and then clears the entry, even while checks are disabled. Reason bit 3 is set when the completion status DW1[15:13] equals 010 (retry) and the looked-up entry does not mark a configuration request.
- R7: `malformed` and `reasonCode` are registered. They reflect the header presented in the cycle before, `malformed` is the OR of the reason bits, several bits may be set together, and both are zero in any cycle after one with `hdrValid` low.
- R8: After reset, the outputs are zero and every tag entry is empty, so a retry completion on any tag is flagged.
- R9: Completions with non-retry status, and TLP types outside the classes above (for example messages, DW0[28:24] = 10xxx), never set a reason bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chkEnable | input | 1 | Enables all optional header rules |
| hdrValid | input | 1 | Header dwords valid this cycle |
| hdrDw0 | input | 32 | Header dword 0 (format, type, TC, attributes, length) |
| hdrDw1 | input | 32 | Header dword 1 (byte enables or completion status) |
| hdrDw2 | input | 32 | Header dword 2 (upper address or completion tag) |
| outReqValid | input | 1 | Outbound non-posted request issued this cycle |
| outReqTag | input | TAG_W | Tag of the outbound request |
| outReqIsCfg | input | 1 | Outbound request is a configuration access |
| malformed | output | 1 | Registered malformed flag |
| reasonCode | output | 4 | Registered rule bits: 0 address, 1 byte enables, 2 IO/config fields, 3 retry completion |

## Verification
The bound assertions check, on every cycle, that a disabled checker flags nothing and that outputs fall to zero after an idle cycle. They also check that the address, single-dword byte-enable and IO/config traffic-class rules raise their own bits one cycle after the offending header. The per-tag memory has no port of its own, so it can only be seen through completion sequences. Only the bench's scenarios can show that an outbound tag is recorded, that it is cleared by a completion even with checks off, and that reset leaves every tag unmarked. The byte-enable and length interactions are swept over every enable pattern at several lengths, including the 1024-dword encoding, and the whole IO/config class is swept over TC and attributes with the enable both on and off.

// File: rtl/tlp_chk_pkg.sv
package tlp_chk_pkg;
  localparam int NUM_RSN   = 4;
  localparam int RSN_ADDR  = 0;
  localparam int RSN_BE    = 1;
  localparam int RSN_IOCFG = 2;
  localparam int RSN_CRS   = 3;
  localparam int LEN_W     = 10;

  localparam logic [4:0] TYPE_MEM  = 5'b00000;
  localparam logic [4:0] TYPE_IO   = 5'b00010;
  localparam logic [4:0] TYPE_CFG0 = 5'b00100;
  localparam logic [4:0] TYPE_CFG1 = 5'b00101;
  localparam logic [4:0] TYPE_CPL  = 5'b01010;
  localparam logic [2:0] STS_RETRY = 3'b010;

  typedef struct packed {
    logic rulesOn;
    logic memReq;
    logic hdr4Dw;
    logic ioCfgReq;
    logic cplSeen;
    logic retrySeen;
  } chkStrobes_t;
endpackage

// File: rtl/tlp_chk_ctrl.sv
module tlp_chk_ctrl
  import tlp_chk_pkg::*;
(
  input  logic        hdrValid,
  input  logic        chkEnable,
  input  logic [7:0]  fmtType,
  input  logic [2:0]  cplStatus,
  output chkStrobes_t strobes
);
  logic [2:0] fmt;
  logic [4:0] tlpType;
  logic       isIoCfgType;

  assign fmt     = fmtType[7:5];
  assign tlpType = fmtType[4:0];
  assign isIoCfgType = (tlpType == TYPE_IO) || (tlpType == TYPE_CFG0) ||
                       (tlpType == TYPE_CFG1);

  always_comb begin
    strobes           = '0;
    strobes.rulesOn   = hdrValid && chkEnable;
    strobes.memReq    = !fmt[2] && (tlpType == TYPE_MEM);
    strobes.hdr4Dw    = fmt[0];
    strobes.ioCfgReq  = !fmt[2] && !fmt[0] && isIoCfgType;
    strobes.cplSeen   = hdrValid && !fmt[2] && !fmt[0] && (tlpType == TYPE_CPL);
    strobes.retrySeen = strobes.cplSeen && (cplStatus == STS_RETRY);
  end
endmodule

// File: rtl/tlp_chk_datapath.sv
module tlp_chk_datapath
  import tlp_chk_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  chkStrobes_t        strobes,
  input  logic [LEN_W-1:0]   lenField,
  input  logic [2:0]         trafficClass,
  input  logic [1:0]         attrBits,
  input  logic [3:0]         firstBe,
  input  logic [3:0]         lastBe,
  input  logic [7:0]         addrHi,
  input  logic [TAG_W-1:0]   cplTag,
  input  logic               outReqValid,
  input  logic [TAG_W-1:0]   outReqTag,
  input  logic               outReqIsCfg,
  output logic               malformed,
  output logic [NUM_RSN-1:0] reasonCode
);
  localparam int DEPTH = 1 << TAG_W;

  logic [DEPTH-1:0]   cfgPending;
  logic [NUM_RSN-1:0] rsnNext;
  logic               singleDw;
  logic               beBad;

  assign singleDw = (lenField == LEN_W'(1));
  assign beBad    = singleDw ? (lastBe != 4'd0)
                             : ((firstBe == 4'd0) || (lastBe == 4'd0));

  always_comb begin
    rsnNext            = '0;
    rsnNext[RSN_ADDR]  = strobes.rulesOn && strobes.memReq && strobes.hdr4Dw &&
                         (addrHi == 8'd0);
    rsnNext[RSN_BE]    = strobes.rulesOn && (strobes.memReq || strobes.ioCfgReq) &&
                         beBad;
    rsnNext[RSN_IOCFG] = strobes.rulesOn && strobes.ioCfgReq &&
                         ((trafficClass != 3'd0) || (attrBits != 2'd0) || !singleDw);
    rsnNext[RSN_CRS]   = strobes.rulesOn && strobes.retrySeen && !cfgPending[cplTag];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgPending <= '0;
    end else begin
      if (strobes.cplSeen) cfgPending[cplTag] <= 1'b0;
      if (outReqValid)     cfgPending[outReqTag] <= outReqIsCfg;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reasonCode <= '0;
      malformed  <= 1'b0;
    end else begin
      reasonCode <= rsnNext;
      malformed  <= |rsnNext;
    end
  end
endmodule

// File: rtl/tlp_hdr_check.sv
module tlp_hdr_check
  import tlp_chk_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               chkEnable,
  input  logic               hdrValid,
  input  logic [31:0]        hdrDw0,
  input  logic [31:0]        hdrDw1,
  input  logic [31:0]        hdrDw2,
  input  logic               outReqValid,
  input  logic [TAG_W-1:0]   outReqTag,
  input  logic               outReqIsCfg,
  output logic               malformed,
  output logic [NUM_RSN-1:0] reasonCode
);
  chkStrobes_t strobes;
  logic        unusedHdrBits;

  assign unusedHdrBits = ^{hdrDw0[23], hdrDw0[19:14], hdrDw0[11:10],
                           hdrDw1[31:16], hdrDw1[12:8], hdrDw2[31:16]};

  tlp_chk_ctrl u_ctrl (
    .hdrValid (hdrValid),
    .chkEnable(chkEnable),
    .fmtType  (hdrDw0[31:24]),
    .cplStatus(hdrDw1[15:13]),
    .strobes  (strobes)
  );

  tlp_chk_datapath #(.TAG_W(TAG_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .lenField    (hdrDw0[LEN_W-1:0]),
    .trafficClass(hdrDw0[22:20]),
    .attrBits    (hdrDw0[13:12]),
    .firstBe     (hdrDw1[3:0]),
    .lastBe      (hdrDw1[7:4]),
    .addrHi      (hdrDw2[7:0]),
    .cplTag      (hdrDw2[8 +: TAG_W]),
    .outReqValid (outReqValid),
    .outReqTag   (outReqTag),
    .outReqIsCfg (outReqIsCfg),
    .malformed   (malformed),
    .reasonCode  (reasonCode)
  );
endmodule

// File: rtl/tlp_hdr_check_sva.sv
module tlp_hdr_check_sva (
  input logic        clk,
  input logic        rstN,
  input logic        chkEnable,
  input logic        hdrValid,
  input logic [31:0] hdrDw0,
  input logic [31:0] hdrDw1,
  input logic [31:0] hdrDw2,
  input logic        malformed,
  input logic [3:0]  reasonCode
);
  logic memHdr, ioCfgHdr, unusedSink;

  assign memHdr   = !hdrDw0[31] && (hdrDw0[28:24] == 5'b00000);
  assign ioCfgHdr = !hdrDw0[31] && !hdrDw0[29] &&
                    ((hdrDw0[28:24] == 5'b00010) || (hdrDw0[28:24] == 5'b00100) ||
                     (hdrDw0[28:24] == 5'b00101));
  assign unusedSink = ^{hdrDw0[30], hdrDw0[23], hdrDw0[19:10], hdrDw1[31:8],
                        hdrDw1[3:0], hdrDw2[31:8]};

  p_disabled_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    (hdrValid && !chkEnable) |=> (reasonCode == 4'd0 && !malformed));

  p_addr_fit_r2: assert property (@(posedge clk) disable iff (!rstN)
    (hdrValid && chkEnable && memHdr && hdrDw0[29] && hdrDw2[7:0] == 8'd0)
      |=> (reasonCode[0] && malformed));

  p_single_be_r4: assert property (@(posedge clk) disable iff (!rstN)
    (hdrValid && chkEnable && memHdr && hdrDw0[9:0] == 10'd1 && hdrDw1[7:4] != 4'd0)
      |=> reasonCode[1]);

  p_iocfg_tc_r5: assert property (@(posedge clk) disable iff (!rstN)
    (hdrValid && chkEnable && ioCfgHdr && hdrDw0[22:20] != 3'd0) |=> reasonCode[2]);

  p_idle_low_r7: assert property (@(posedge clk) disable iff (!rstN)
    !hdrValid |=> (!malformed && reasonCode == 4'd0));
endmodule

bind tlp_hdr_check tlp_hdr_check_sva u_sva (
  .clk       (clk),
  .rstN      (rstN),
  .chkEnable (chkEnable),
  .hdrValid  (hdrValid),
  .hdrDw0    (hdrDw0),
  .hdrDw1    (hdrDw1),
  .hdrDw2    (hdrDw2),
  .malformed (malformed),
  .reasonCode(reasonCode)
);

// File: tb/tlp_hdr_check_bench.sv
`timescale 1ns/1ps
module tlp_hdr_check_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        chkEnable = 1'b0;
  logic        hdrValid = 1'b0;
  logic [31:0] hdrDw0 = '0, hdrDw1 = '0, hdrDw2 = '0;
  logic        outReqValid = 1'b0;
  logic [7:0]  outReqTag = '0;
  logic        outReqIsCfg = 1'b0;
  logic        malformed;
  logic [3:0]  reasonCode;

  int checks = 0;
  int fails  = 0;
  logic refCfg [256];

  always #10 clk = ~clk;

  tlp_hdr_check u_tlp_hdr_check (
    .clk(clk), .rstN(rstN), .chkEnable(chkEnable), .hdrValid(hdrValid),
    .hdrDw0(hdrDw0), .hdrDw1(hdrDw1), .hdrDw2(hdrDw2),
    .outReqValid(outReqValid), .outReqTag(outReqTag), .outReqIsCfg(outReqIsCfg),
    .malformed(malformed), .reasonCode(reasonCode)
  );

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  function automatic logic [3:0] refReason(input logic en, input logic [31:0] d0,
                                           input logic [31:0] d1, input logic [31:0] d2);
    logic [3:0] r;
    logic mem, ioCfg, cpl, one, beBad;
    r     = '0;
    mem   = (d0[31:29] <= 3'b011) && (d0[28:24] == 5'd0);
    ioCfg = (d0[31:29] == 3'b000 || d0[31:29] == 3'b010) &&
            (d0[28:24] == 5'd2 || d0[28:24] == 5'd4 || d0[28:24] == 5'd5);
    cpl   = (d0[31:29] == 3'b000 || d0[31:29] == 3'b010) && (d0[28:24] == 5'd10);
    one   = (d0[9:0] == 10'd1);
    beBad = one ? (d1[7:4] != 0) : (d1[3:0] == 0 || d1[7:4] == 0);
    if (en) begin
      r[0] = mem && d0[29] && d2[7:0] == 8'd0;
      r[1] = (mem || ioCfg) && beBad;
      r[2] = ioCfg && (d0[22:20] != 0 || d0[13:12] != 0 || !one);
      r[3] = cpl && d1[15:13] == 3'b010 && !refCfg[d2[15:8]];
    end
    return r;
  endfunction

  task automatic compare(input logic [4:0] act, input logic [4:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual flag/reason %b expected %b (dw0=%h dw1=%h dw2=%h)",
               req, act, exp, hdrDw0, hdrDw1, hdrDw2);
    end
  endtask

  // Called at a falling edge; returns at a falling edge.
  task automatic sendHdr(input logic en, input logic [31:0] d0, input logic [31:0] d1,
                         input logic [31:0] d2, input string req);
    logic [3:0] e;
    e = refReason(en, d0, d1, d2);
    if ((d0[31:29] == 3'b000 || d0[31:29] == 3'b010) && d0[28:24] == 5'd10)
      refCfg[d2[15:8]] = 1'b0;
    chkEnable = en; hdrDw0 = d0; hdrDw1 = d1; hdrDw2 = d2; hdrValid = 1'b1;
    @(posedge clk); @(negedge clk);
    compare({malformed, reasonCode}, {|e, e}, req);
    hdrValid = 1'b0;
    @(posedge clk); @(negedge clk);
    compare({malformed, reasonCode}, 5'd0, "R7 idle");
  endtask

  task automatic sendOut(input logic [7:0] tag, input logic isCfg);
    outReqValid = 1'b1; outReqTag = tag; outReqIsCfg = isCfg;
    refCfg[tag] = isCfg;
    @(posedge clk); @(negedge clk);
    outReqValid = 1'b0;
  endtask

  function automatic logic [31:0] mkDw0(input logic [2:0] fmt, input logic [4:0] typ,
                                        input logic [2:0] tc, input logic [1:0] attr,
                                        input logic [9:0] len);
    return {fmt, typ, 1'b0, tc, 6'd0, attr, 2'd0, len};
  endfunction

  initial begin
    logic [9:0] lens [5];
    logic [4:0] ioTypes [3];
    lens = '{10'd0, 10'd1, 10'd2, 10'd3, 10'd1023};
    ioTypes = '{5'd2, 5'd4, 5'd5};
    for (int i = 0; i < 256; i++) refCfg[i] = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare({malformed, reasonCode}, 5'd0, "R8 reset outputs");
    rstN = 1'b1;
    @(negedge clk);

    // R8: fresh table, retry completion on a tag is flagged
    sendHdr(1'b1, mkDw0(3'b000, 5'd10, 0, 0, 10'd0), 32'h0000_4000, 32'h0000_3700, "R8 empty table");

    // R3 / R4 byte-enable sweep on 3-DW memory reads and writes
    for (int l = 0; l < 5; l++)
      for (int b = 0; b < 256; b++)
        sendHdr(1'b1, mkDw0(b[0] ? 3'b010 : 3'b000, 5'd0, 0, 0, lens[l]), {24'd0, b[7:0]},
                32'h0, lens[l] == 10'd1 ? "R4 single-dword BE" : "R3 multi-dword BE");

    // R2 address sweep, 4-DW and 3-DW
    for (int a = 0; a < 256; a++) begin
      sendHdr(1'b1, mkDw0(3'b001, 5'd0, 0, 0, 10'd1), 32'h0000_000F, {24'd0, a[7:0]}, "R2 4-DW read address");
      sendHdr(1'b1, mkDw0(3'b011, 5'd0, 3'(a), 0, 10'd4), 32'h0000_00FF, {24'd0, a[7:0]}, "R2 4-DW write address");
    end
    sendHdr(1'b1, mkDw0(3'b000, 5'd0, 0, 0, 10'd1), 32'h0000_000F, 32'h0, "R2 3-DW not flagged");

    // R5 and R1: IO/config sweep with enable on and off
    for (int en = 0; en < 2; en++)
      for (int t = 0; t < 3; t++)
        for (int w = 0; w < 2; w++)
          for (int tc = 0; tc < 8; tc++)
            for (int at = 0; at < 4; at++)
              for (int ln = 1; ln < 3; ln++)
                sendHdr(en[0], mkDw0(w[0] ? 3'b010 : 3'b000, ioTypes[t], 3'(tc), 2'(at), 10'(ln)),
                        32'h0000_000F, 32'h0, en[0] ? "R5 io/cfg fields" : "R1 disabled io/cfg");

    // R1: disabled memory violations
    for (int b = 0; b < 16; b++)
      sendHdr(1'b0, mkDw0(3'b001, 5'd0, 0, 0, 10'd2), {24'd0, b[3:0], 4'd0}, 32'h0, "R1 disabled memory");

    // R6: record tags then answer with retry completions
    for (int g = 0; g < 256; g++) sendOut(8'(g), g[0]);
    for (int g = 0; g < 256; g++)
      sendHdr(1'b1, mkDw0(3'b000, 5'd10, 0, 0, 10'd0), 32'h0000_4000, {16'd0, 8'(g), 8'd0}, "R6 retry by tag");
    sendOut(8'd5, 1'b1);
    sendHdr(1'b1, mkDw0(3'b000, 5'd10, 0, 0, 10'd0), 32'h0000_4000, 32'h0000_0500, "R6 config tag accepted");
    sendHdr(1'b1, mkDw0(3'b000, 5'd10, 0, 0, 10'd0), 32'h0000_4000, 32'h0000_0500, "R6 entry cleared");
    sendOut(8'd9, 1'b1);
    sendHdr(1'b0, mkDw0(3'b010, 5'd10, 0, 0, 10'd1), 32'h0000_0000, 32'h0000_0900, "R1 disabled completion");
    sendHdr(1'b1, mkDw0(3'b000, 5'd10, 0, 0, 10'd0), 32'h0000_4000, 32'h0000_0900, "R6 cleared while disabled");

    // R9: non-retry completions and messages
    for (int s = 0; s < 8; s++)
      if (s != 2)
        sendHdr(1'b1, mkDw0(3'b010, 5'd10, 0, 0, 10'd1), {16'd0, 3'(s), 13'd0}, 32'h0000_1100, "R9 non-retry completion");
    sendHdr(1'b1, mkDw0(3'b001, 5'b10000, 3'd7, 2'd3, 10'd5), 32'h0000_00F0, 32'h0, "R9 message ignored");

    // R7: combined rule bits
    sendHdr(1'b1, mkDw0(3'b010, 5'd2, 3'd1, 2'd0, 10'd2), 32'h0000_000F, 32'h0, "R7 bits 1 and 2");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule